// File: doc/BRIEF.md
# Device Endpoint Register Set

This block holds the register state for a single device-side endpoint of a USB controller. One direction is fixed per instance by a parameter, and so is the endpoint index. The block owns three 32-bit registers: a control word, a sticky interrupt flag word and a transfer-size word. They sit in a 32-byte window whose base address follows from the direction and the index. Software enables the endpoint by writing the control word. A data-path stub, which is outside this block, watches the enable level and the programmed byte count. When its transfer is over, it returns a one-cycle completion pulse carrying the number of bytes moved.

On completion the block does the bookkeeping. The enable bit drops by itself and the transfer-complete flag is raised. An IN endpoint also raises its TX-FIFO-empty flag. An OUT endpoint reduces its remaining byte count, and it refuses a received packet that would not fit in that count. Writing the disable command to an active endpoint stops it and flags the event. The two NAK command bits act only as strobes and are never kept. The OR of all interrupt flags goes to a device-level interrupt aggregator.

Top module: `ep_regs`

## Requirements
- R1: After reset, all three registers read 0, and `ep_enable` and `ep_pending` are low.
- R2: Writing the control word with bit 31 = 1 and bit 30 = 0 sets the enable bit. `ep_enable` follows the stored bit 31 from the next cycle. The enable bit can only rise through such a write.
- R3: A control write with bit 30 = 1 (disable) stores enable = 0, even when bit 31 is also 1. If the endpoint was enabled, it also sets interrupt bit 1. If it was not enabled, interrupt bit 1 is left unchanged.
- R4: Control bits 30, 27 and 26 always read back as 0. Every other control bit except the enable bit reads back exactly as last written.
- R5: Writing the interrupt word clears each flag whose data bit is 1. Only bits 0, 1, 2, 3, 7 and 9 exist; all other bits read 0. If a flag is set and cleared in the same cycle, the set wins.
- R6: A completion pulse on an enabled IN endpoint sets interrupt bits 0 and 7 and clears enable. It leaves the transfer size unchanged.
- R7: A completion pulse of N bytes on an enabled OUT endpoint, with N no greater than the low 19 bits of the transfer size, subtracts N from the transfer size. It also clears enable and sets interrupt bit 0 only (not bit 7).
- R8: On an OUT endpoint, a completion of N bytes with N greater than the low 19 bits of the transfer size is dropped. Size, enable and flags all stay as they were, whatever the upper size bits hold.
- R9: A completion pulse while enable is 0 has no effect.
- R10: `ep_pending` is high exactly when at least one interrupt flag is set.
- R11: The `side_evt` pulses set interrupt flags as follows: bit 0 of `side_evt` sets flag 2 (bus error), bit 1 sets flag 3 (setup done or timeout), and bit 2 sets flag 9 (buffer not available).
- R12: The window base is 0x900 + 32·index for IN and 0xB00 + 32·index for OUT. Control is at +0x00, interrupt at +0x08 and size at +0x10. Writes anywhere else are ignored, and reads anywhere else return 0.
- R13: `xfer_len` always shows the low 19 bits of the transfer-size word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Byte address in the controller window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational; 0 outside this endpoint's registers) |
| xfer_done | input | 1 | One-cycle completion pulse from the data path |
| xfer_bytes | input | CNT_W (19) | Byte count carried by the completion pulse |
| side_evt | input | 3 | Event pulses: [0] bus error, [1] setup/timeout, [2] buffer not available |
| ep_enable | output | 1 | Stored enable level |
| ep_pending | output | 1 | OR of all interrupt flags |
| xfer_len | output | CNT_W (19) | Low 19 bits of the transfer-size word |

## Verification
The hardest case to reach is a completion whose byte count sits right at the fit boundary of an OUT endpoint. The bench programs a remaining count, then sends one completion a single byte over it, which must be dropped. It then sends one exactly equal to it, which must drain the count to zero. It repeats the oversize case with the upper size bits set, so that only the 19-bit field can decide. The set-versus-clear race on the flags is reached by lining up a write-one-to-clear and a side event pulse in the same clock cycle.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 5;

    // control word bits
    localparam int EN_BIT  = 31;
    localparam int DIS_BIT = 30;
    localparam logic [REG_W-1:0] CTRL_STROBES = 32'h4C00_0000;  // 30, 27, 26

    // interrupt flag positions
    localparam int F_DONE    = 0;
    localparam int F_DIS     = 1;
    localparam int F_BUSERR  = 2;
    localparam int F_SETUPTO = 3;
    localparam int F_TXEMPTY = 7;
    localparam int F_NOBUF   = 9;
    localparam logic [REG_W-1:0] FLAG_MASK = 32'h0000_028F;

    // register offsets inside the 32-byte window
    localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [OFS_W-1:0] OFS_FLAG = 5'h08;
    localparam logic [OFS_W-1:0] OFS_SIZE = 5'h10;

    typedef struct packed {
        logic ctrl;
        logic flag;
        logic size;
    } reg_sel_t;

    typedef struct packed {
        logic done;
        logic dis;
        logic buserr;
        logic setupto;
        logic txempty;
        logic nobuf;
    } flag_set_t;

    function automatic int win_base(bit is_in, int idx);
        return (is_in ? 32'h900 : 32'hB00) + idx * (1 << OFS_W);
    endfunction

    function automatic logic [REG_W-1:0] flag_vec(flag_set_t s);
        logic [REG_W-1:0] v;
        v = '0;
        v[F_DONE]    = s.done;
        v[F_DIS]     = s.dis;
        v[F_BUSERR]  = s.buserr;
        v[F_SETUPTO] = s.setupto;
        v[F_TXEMPTY] = s.txempty;
        v[F_NOBUF]   = s.nobuf;
        return v;
    endfunction

endpackage

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
    import ep_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             cmpl,
    output logic [REG_W-1:0] ctrl_q,
    output logic             dis_evt
);

    logic [REG_W-1:0] ctrl_d;

    // disable command only counts as an event when the endpoint is live
    assign dis_evt = wr && wdata[DIS_BIT] && ctrl_q[EN_BIT];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d         = wdata & ~CTRL_STROBES;
            ctrl_d[EN_BIT] = wdata[EN_BIT] && !wdata[DIS_BIT];
        end
        if (cmpl) begin
            ctrl_d[EN_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/ep_flag_reg.sv
module ep_flag_reg
    import ep_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] wdata,
    input  flag_set_t        set,
    output logic [REG_W-1:0] flag_q
);

    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] flag_d;

    assign clr_mask = clr_wr ? (wdata & FLAG_MASK) : '0;
    // a set in the same cycle overrides a clear
    assign flag_d   = ((flag_q & ~clr_mask) | flag_vec(set)) & FLAG_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/ep_size_reg.sv
module ep_size_reg
    import ep_regs_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             dec,
    input  logic [CNT_W-1:0] bytes,
    output logic [REG_W-1:0] size_q,
    output logic [CNT_W-1:0] remain,
    output logic             fits
);

    localparam int PAD_W = REG_W - CNT_W;

    assign remain = size_q[CNT_W-1:0];
    assign fits   = (bytes <= remain);

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
        end else if (wr) begin
            size_q <= wdata;
        end else if (dec) begin
            size_q <= size_q - {{PAD_W{1'b0}}, bytes};
        end
    end

endmodule

// File: rtl/ep_regs.sv
module ep_regs
    import ep_regs_pkg::*;
#(
    parameter bit IS_IN    = 1'b0,
    parameter int EP_INDEX = 1,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              xfer_done,
    input  logic [CNT_W-1:0]  xfer_bytes,
    input  logic [2:0]        side_evt,
    output logic              ep_enable,
    output logic              ep_pending,
    output logic [CNT_W-1:0]  xfer_len
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(win_base(IS_IN, EP_INDEX));

    logic             in_win;
    logic [OFS_W-1:0] ofs;
    reg_sel_t         wsel;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] size_q;
    logic             dis_evt;
    logic             fits;
    logic             accept;
    flag_set_t        fset;

    assign in_win = (bus_addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    assign ofs    = bus_addr[OFS_W-1:0];

    assign wsel.ctrl = bus_wr && in_win && (ofs == OFS_CTRL);
    assign wsel.flag = bus_wr && in_win && (ofs == OFS_FLAG);
    assign wsel.size = bus_wr && in_win && (ofs == OFS_SIZE);

    // completion is taken only by a live endpoint; OUT must also fit
    generate
        if (IS_IN) begin : g_in
            assign accept = xfer_done && ctrl_q[EN_BIT];
        end else begin : g_out
            assign accept = xfer_done && ctrl_q[EN_BIT] && fits;
        end
    endgenerate

    assign fset.done    = accept;
    assign fset.dis     = dis_evt;
    assign fset.buserr  = side_evt[0];
    assign fset.setupto = side_evt[1];
    assign fset.txempty = accept && IS_IN;
    assign fset.nobuf   = side_evt[2];

    ep_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wsel.ctrl),
        .wdata   (bus_wdata),
        .cmpl    (accept),
        .ctrl_q  (ctrl_q),
        .dis_evt (dis_evt)
    );

    ep_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .clr_wr (wsel.flag),
        .wdata  (bus_wdata),
        .set    (fset),
        .flag_q (flag_q)
    );

    ep_size_reg #(.CNT_W(CNT_W)) u_size (
        .clk    (clk),
        .rst    (rst),
        .wr     (wsel.size),
        .wdata  (bus_wdata),
        .dec    (accept && !IS_IN),
        .bytes  (xfer_bytes),
        .size_q (size_q),
        .remain (xfer_len),
        .fits   (fits)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            case (ofs)
                OFS_CTRL: bus_rdata = ctrl_q;
                OFS_FLAG: bus_rdata = flag_q;
                OFS_SIZE: bus_rdata = size_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign ep_enable  = ctrl_q[EN_BIT];
    assign ep_pending = |flag_q;

endmodule

// File: rtl/ep_regs_chk.sv
module ep_regs_chk
    import ep_regs_pkg::*;
#(
    parameter bit IS_IN    = 1'b0,
    parameter int EP_INDEX = 1,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              xfer_done,
    input logic [CNT_W-1:0]  xfer_bytes,
    input logic              ep_enable,
    input logic              ep_pending,
    input logic [CNT_W-1:0]  xfer_len,
    input logic [REG_W-1:0]  flag_q
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(win_base(IS_IN, EP_INDEX));

    logic ctrl_hit;
    logic taken;
    logic out_ep;

    assign out_ep   = (IS_IN == 1'b0);
    assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);
    assign taken    = xfer_done && ep_enable && (!out_ep || xfer_bytes <= xfer_len);

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_enable) |-> $past(ctrl_hit));  // R2

    AST_DISABLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && bus_wdata[DIS_BIT] && ep_enable) |=> (!ep_enable && flag_q[F_DIS]));  // R3

    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
        taken |=> !ep_enable);  // R6

    AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        taken |=> (flag_q[F_DONE] && ep_pending));  // R7

    AST_COUNT_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (out_ep && taken && !bus_wr) |=> (xfer_len == $past(xfer_len) - $past(xfer_bytes)));  // R7

    AST_OVERSIZE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (out_ep && xfer_done && (xfer_bytes > xfer_len) && !bus_wr)
            |=> ($stable(xfer_len) && $stable(ep_enable)));  // R8

endmodule

bind ep_regs ep_regs_chk #(
    .IS_IN    (IS_IN),
    .EP_INDEX (EP_INDEX),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
) u_ep_regs_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .xfer_done  (xfer_done),
    .xfer_bytes (xfer_bytes),
    .ep_enable  (ep_enable),
    .ep_pending (ep_pending),
    .xfer_len   (xfer_len),
    .flag_q     (flag_q)
);

// File: tb/test_ep_regs.sv
module test_ep_regs;

    localparam int CNT_W = 19;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_DN = 2'd2;
    localparam logic [1:0] OP_PN = 2'd3;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] val;
    } vec_t;

    // OUT endpoint 1: control 0xB20, flags 0xB28, size 0xB30
    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{4'd13, OP_WR, 12'hB30, 32'h0000_0100},
        '{4'd13, OP_RD, 12'hB30, 32'h0000_0100},
        '{4'd4,  OP_WR, 12'hB20, 32'h8C00_0005},
        '{4'd4,  OP_RD, 12'hB20, 32'h8000_0005},   // R4 strobes dropped
        '{4'd2,  OP_PN, 12'h000, 32'h0000_0002},   // R2 enable on, nothing pending
        '{4'd7,  OP_DN, 12'h000, 32'h0000_0040},
        '{4'd7,  OP_RD, 12'hB30, 32'h0000_00C0},   // R7 count reduced
        '{4'd7,  OP_RD, 12'hB20, 32'h0000_0005},   // R7 enable self-clears
        '{4'd7,  OP_RD, 12'hB28, 32'h0000_0001},   // R7 only done flag
        '{4'd10, OP_PN, 12'h000, 32'h0000_0001},   // R10
        '{4'd5,  OP_WR, 12'hB28, 32'h0000_0001},
        '{4'd5,  OP_RD, 12'hB28, 32'h0000_0000},   // R5 cleared
        '{4'd2,  OP_WR, 12'hB20, 32'h8000_0000},
        '{4'd8,  OP_DN, 12'h000, 32'h0000_00C1},   // R8 one byte too many
        '{4'd8,  OP_RD, 12'hB30, 32'h0000_00C0},
        '{4'd8,  OP_RD, 12'hB28, 32'h0000_0000},
        '{4'd8,  OP_PN, 12'h000, 32'h0000_0002},
        '{4'd7,  OP_DN, 12'h000, 32'h0000_00C0},   // R7 exact fit
        '{4'd7,  OP_RD, 12'hB30, 32'h0000_0000},
        '{4'd7,  OP_RD, 12'hB28, 32'h0000_0001},
        '{4'd5,  OP_WR, 12'hB28, 32'hFFFF_FFFF},
        '{4'd8,  OP_WR, 12'hB30, 32'hFFF8_0010},
        '{4'd2,  OP_WR, 12'hB20, 32'h8000_0000},
        '{4'd8,  OP_DN, 12'h000, 32'h0000_0011},   // R8 upper bits do not count
        '{4'd8,  OP_RD, 12'hB30, 32'hFFF8_0010},
        '{4'd8,  OP_PN, 12'h000, 32'h0000_0002},
        '{4'd3,  OP_WR, 12'hB20, 32'h4000_0000},   // R3 disable while live
        '{4'd3,  OP_RD, 12'hB20, 32'h0000_0000},
        '{4'd3,  OP_RD, 12'hB28, 32'h0000_0002},
        '{4'd5,  OP_WR, 12'hB28, 32'h0000_0002},
        '{4'd3,  OP_WR, 12'hB20, 32'h4000_0000},   // R3 disable while idle
        '{4'd3,  OP_RD, 12'hB28, 32'h0000_0000},
        '{4'd9,  OP_DN, 12'h000, 32'h0000_0004},   // R9 not enabled
        '{4'd9,  OP_RD, 12'hB30, 32'hFFF8_0010},
        '{4'd9,  OP_RD, 12'hB28, 32'h0000_0000},
        '{4'd3,  OP_WR, 12'hB20, 32'hC000_0000},   // R3 disable beats enable
        '{4'd3,  OP_PN, 12'h000, 32'h0000_0000},
        '{4'd3,  OP_RD, 12'hB28, 32'h0000_0000},
        '{4'd12, OP_RD, 12'hB24, 32'h0000_0000}    // R12 hole reads zero
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      rdata_out, rdata_in;
    logic             done_out = 1'b0, done_in = 1'b0;
    logic [CNT_W-1:0] bytes_out = '0, bytes_in = '0;
    logic [2:0]       side_out = '0, side_in = '0;
    logic             en_out, en_in, pend_out, pend_in;
    logic [CNT_W-1:0] len_out, len_in;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ep_regs #(.IS_IN(1'b0), .EP_INDEX(1)) i_ep_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_out), .xfer_done(done_out),
        .xfer_bytes(bytes_out), .side_evt(side_out), .ep_enable(en_out),
        .ep_pending(pend_out), .xfer_len(len_out)
    );

    ep_regs #(.IS_IN(1'b1), .EP_INDEX(2)) i_ep_regs_in (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_in), .xfer_done(done_in),
        .xfer_bytes(bytes_in), .side_evt(side_in), .ep_enable(en_in),
        .ep_pending(pend_in), .xfer_len(len_in)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [11:0] a, logic [31:0] exp, bit from_in);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, from_in ? rdata_in : rdata_out, exp);
    endtask

    task automatic cmpl(bit to_in, logic [CNT_W-1:0] n);
        @(negedge clk);
        if (to_in) begin done_in = 1'b1; bytes_in = n; end
        else begin done_out = 1'b1; bytes_out = n; end
        @(negedge clk);
        done_in = 1'b0; done_out = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state of both instances
        rd("R1 out ctrl", 12'hB20, 32'h0, 1'b0);
        rd("R1 out flag", 12'hB28, 32'h0, 1'b0);
        rd("R1 out size", 12'hB30, 32'h0, 1'b0);
        rd("R1 in ctrl",  12'h940, 32'h0, 1'b1);
        check("R1 pins", {30'd0, en_out | en_in, pend_out | pend_in}, 32'h0);

        // table walk on the OUT endpoint
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_WR: wr(VECS[i].addr, VECS[i].val);
                OP_RD: rd(tag, VECS[i].addr, VECS[i].val, 1'b0);
                OP_DN: cmpl(1'b0, VECS[i].val[CNT_W-1:0]);
                default: begin
                    @(negedge clk);
                    check(tag, {30'd0, en_out, pend_out}, VECS[i].val);
                end
            endcase
        end

        // IN endpoint 2: control 0x940, flags 0x948, size 0x950
        wr(12'h950, 32'h0000_0020);
        wr(12'h940, 32'h8000_0000);
        @(negedge clk);
        check("R2 in enable", {31'd0, en_in}, 32'h1);
        check("R13 in xfer_len", {13'd0, len_in}, 32'h20);
        cmpl(1'b1, 19'd5);
        rd("R6 in flags", 12'h948, 32'h0000_0081, 1'b1);
        rd("R6 in size kept", 12'h950, 32'h0000_0020, 1'b1);
        check("R6 in enable dropped", {31'd0, en_in}, 32'h0);
        check("R10 in pending", {31'd0, pend_in}, 32'h1);

        wr(12'h948, 32'hFFFF_FFFF);
        rd("R5 in all cleared", 12'h948, 32'h0, 1'b1);
        check("R10 in pending low", {31'd0, pend_in}, 32'h0);

        // R11 side events
        @(negedge clk);
        side_in = 3'b111;
        @(negedge clk);
        side_in = 3'b000;
        rd("R11 side flags", 12'h948, 32'h0000_020C, 1'b1);

        // R5 clear bits 2 and 3 while bit 2 is set again in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h948; bus_wdata = 32'h0000_000C; side_in = 3'b001;
        @(negedge clk);
        bus_wr = 1'b0; side_in = 3'b000;
        rd("R5 set beats clear", 12'h948, 32'h0000_0204, 1'b1);

        // R12 write to the neighbouring IN window is ignored
        wr(12'h960, 32'h8000_0000);
        @(negedge clk);
        check("R12 neighbour write ignored", {31'd0, en_in}, 32'h0);
        rd("R12 neighbour read zero", 12'h960, 32'h0, 1'b1);
        rd("R12 out unaffected by in address", 12'h940, 32'h0, 1'b0);

        // R9 on the IN side: completion while idle
        cmpl(1'b1, 19'd1);
        rd("R9 in idle completion", 12'h948, 32'h0000_0204, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule